// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block holds the transmit error count (TEC) and the receive error count (REC) of a CAN node. It derives the node's confinement state from those two counts. The protocol engine reports what it sees on the bus as single-cycle event pulses: a failed transmission, a receive error, the bus still dominant after an error flag, a bit error while sending a flag, runs of dominant bits after a flag, and frames that were sent or received cleanly. The block applies the weighted count changes those events call for.

The outputs are both counts, a two-bit state code and a select that tells the engine which error flag to send: active or passive. Recovery from bus off is handled elsewhere. That logic drives the clear input once its recovery condition is met. Until the clear arrives, the counters stay frozen in bus off.

All count changes caused by the events in one cycle take effect at the next rising clock edge. The state and flag select follow the new counts combinationally.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, and in the cycle after a pulse on `clr_i`, both counts are 0 and the state is active. A clear overrides every other event in the same cycle.
- R2: A pulse on `tx_err_i` adds 8 to TEC, unless R8 exempts it.
- R3: A pulse on `rx_err_i` adds 1 to REC.
- R4: A pulse on `rx_dom_post_flag_i` adds 8 to REC. A pulse on `rx_flag_bit_err_i` adds 8 to REC. Both in one cycle add 16.
- R5: A pulse on `dom_run_i` adds 8 to TEC when `role_tx_i` is 1, and adds 8 to REC when `role_tx_i` is 0.
- R6: A pulse on `tx_ok_i` subtracts 1 from TEC. A TEC of 0 stays at 0.
- R7: A pulse on `rx_ok_i` subtracts 1 from REC when REC is from 1 to 127. A REC of 0 stays at 0. A REC above 127 is set to 127.
- R8: A `tx_err_i` leaves TEC unchanged in two cases. The first is when `tx_arb_stuff_i` is 1. The second is when `tx_ack_err_i` is 1 and the node is currently passive.
- R9: `state_o` is 0 (active) while both counts are 127 or less. It is 1 (passive) when either count exceeds 127. It is 2 (bus off) when TEC is 256 or more. REC alone never gives bus off.
- R10: `flag_passive_o` is 1 exactly when `state_o` is 1 (passive).
- R11: The counts saturate and never wrap. REC stops at 255.
- R12: In bus off, every event except the clear is ignored, and the counts hold their values.
- R13: Events in the same cycle combine. All increments are summed and saturated first, and then a decrement is applied to that result, including the REC reload to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear both counts (from the recovery logic) |
| tx_err_i | input | 1 | Transmit error pulse |
| tx_ack_err_i | input | 1 | Qualifies `tx_err_i`: the error was an ACK error and no dominant bit was seen during the passive flag |
| tx_arb_stuff_i | input | 1 | Qualifies `tx_err_i`: stuff error during arbitration |
| rx_err_i | input | 1 | Receive error pulse |
| rx_dom_post_flag_i | input | 1 | Dominant level seen on the first bit after the node's error flag |
| rx_flag_bit_err_i | input | 1 | Receiver bit error while sending an active error flag or overload flag |
| dom_run_i | input | 1 | Dominant run after a flag reached its limit (14 bits, or each further 8 bits) |
| role_tx_i | input | 1 | Node is the transmitter for `dom_run_i` |
| tx_ok_i | input | 1 | Frame transmitted without error |
| rx_ok_i | input | 1 | Frame received without error |
| tec_o | output | TEC_W | Transmit error count |
| rec_o | output | REC_W | Receive error count |
| state_o | output | 2 | 0 active, 1 passive, 2 bus off |
| flag_passive_o | output | 1 | Engine must send passive error flags |

## Verification
Every count change is due exactly one rising edge after the cycle in which its event pulse is held. `state_o` and `flag_passive_o` follow in that same cycle, because they are decoded from the registered counts without a further register. The bench drives each event set just after a falling edge. It advances its own model at the following rising edge and compares every output at the next falling edge. Every clock of the run is therefore checked against the value due in that cycle.

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int BIG_STEP   = 8,
  parameter int PASS_LIM   = 127,
  parameter int OFF_LIM    = 256,
  parameter int REC_RELOAD = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tx_err_i,
  input  logic             tx_ack_err_i,
  input  logic             tx_arb_stuff_i,
  input  logic             rx_err_i,
  input  logic             rx_dom_post_flag_i,
  input  logic             rx_flag_bit_err_i,
  input  logic             dom_run_i,
  input  logic             role_tx_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             flag_passive_o
);
  localparam int TX = TEC_W + 2;
  localparam int RX = REC_W + 2;
  localparam logic [TX-1:0]    T_STEP  = TX'(BIG_STEP);
  localparam logic [RX-1:0]    R_STEP  = RX'(BIG_STEP);
  localparam logic [RX-1:0]    R_ONE   = RX'(1);
  localparam logic [TX-1:0]    T_MAX   = TX'((1 << TEC_W) - 1);
  localparam logic [RX-1:0]    R_MAX   = RX'((1 << REC_W) - 1);
  localparam logic [TEC_W-1:0] T_PASS  = TEC_W'(PASS_LIM);
  localparam logic [REC_W-1:0] R_PASS  = REC_W'(PASS_LIM);
  localparam logic [TEC_W-1:0] T_OFF   = TEC_W'(OFF_LIM);
  localparam logic [REC_W-1:0] R_RLD   = REC_W'(REC_RELOAD);
  localparam logic [1:0] ST_ACTIVE = 2'd0, ST_PASSIVE = 2'd1, ST_OFF = 2'd2;

  logic [TEC_W-1:0] tec_q, tec_d, tec_sat;
  logic [REC_W-1:0] rec_q, rec_d, rec_sat;
  logic [TX-1:0]    tec_sum;
  logic [RX-1:0]    rec_sum;
  logic             bus_off, passive, tx_exempt;

  assign bus_off   = tec_q >= T_OFF;
  assign passive   = !bus_off && (tec_q > T_PASS || rec_q > R_PASS);
  assign tx_exempt = tx_arb_stuff_i || (tx_ack_err_i && passive);

  always_comb begin
    tec_sum = TX'(tec_q)
            + ((tx_err_i && !tx_exempt) ? T_STEP : '0)
            + ((dom_run_i && role_tx_i) ? T_STEP : '0);
    tec_sat = (tec_sum > T_MAX) ? T_MAX[TEC_W-1:0] : tec_sum[TEC_W-1:0];
    tec_d   = (tx_ok_i && tec_sat != '0) ? tec_sat - 1'b1 : tec_sat;

    rec_sum = RX'(rec_q)
            + (rx_err_i ? R_ONE : '0)
            + (rx_dom_post_flag_i ? R_STEP : '0)
            + (rx_flag_bit_err_i ? R_STEP : '0)
            + ((dom_run_i && !role_tx_i) ? R_STEP : '0);
    rec_sat = (rec_sum > R_MAX) ? R_MAX[REC_W-1:0] : rec_sum[REC_W-1:0];
    if (!rx_ok_i)              rec_d = rec_sat;
    else if (rec_sat > R_PASS) rec_d = R_RLD;
    else if (rec_sat != '0)    rec_d = rec_sat - 1'b1;
    else                       rec_d = rec_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (clr_i) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (!bus_off) begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

  assign tec_o          = tec_q;
  assign rec_o          = rec_q;
  assign state_o        = bus_off ? ST_OFF : (passive ? ST_PASSIVE : ST_ACTIVE);
  assign flag_passive_o = passive;

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (tec_o == '0 && rec_o == '0 && state_o == ST_ACTIVE));

  p_busoff_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_OFF && !clr_i) |=> ($stable(tec_o) && $stable(rec_o)));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok_i && rec_o > R_PASS && state_o != ST_OFF && !clr_i) |=> rec_o == R_RLD);

  p_stuff_exempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_arb_stuff_i && !tx_ok_i && !(dom_run_i && role_tx_i) && !clr_i) |=> $stable(tec_o));

  p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && tec_o != '0) |=> ({1'b0, tec_o} + 1'b1 >= {1'b0, $past(tec_o)}));

  p_flag_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_passive_o |-> (state_o == ST_PASSIVE));
endmodule

// File: tb/sim_can_fault_conf.sv
module sim_can_fault_conf;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic clr, txe, ack, stf, rxe, dpf, fbe, drn, rtx, txok, rxok;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] st;
  logic       fp;
  int checks = 0, fails = 0;
  int m_t = 0, m_r = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  can_fault_conf u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tx_err_i(txe), .tx_ack_err_i(ack),
    .tx_arb_stuff_i(stf), .rx_err_i(rxe), .rx_dom_post_flag_i(dpf),
    .rx_flag_bit_err_i(fbe), .dom_run_i(drn), .role_tx_i(rtx), .tx_ok_i(txok),
    .rx_ok_i(rxok), .tec_o(tec), .rec_o(rec), .state_o(st), .flag_passive_o(fp));

  function automatic int exp_state(int t, int r);
    if (t >= 256) return 2;
    if (t > 127 || r > 127) return 1;
    return 0;
  endfunction

  task automatic zero();
    {clr, txe, ack, stf, rxe, dpf, fbe, drn, rtx, txok, rxok} = '0;
  endtask

  task automatic compare(string tag);
    int es;
    es = exp_state(m_t, m_r);
    checks++;
    if (int'(tec) != m_t || int'(rec) != m_r || int'(st) != es || fp != (es == 1)) begin
      fails++;
      $display("FAIL %s: tec=%0d rec=%0d st=%0d fp=%0b expected tec=%0d rec=%0d st=%0d fp=%0b",
               tag, tec, rec, st, fp, m_t, m_r, es, es == 1);
    end
  endtask

  task automatic step(string tag);
    int ti, ri;
    if (clr) begin
      m_t = 0; m_r = 0;
    end else if (m_t < 256) begin
      ti = 0; ri = 0;
      if (txe && !(stf || (ack && exp_state(m_t, m_r) == 1))) ti += 8;
      if (drn && rtx) ti += 8;
      if (drn && !rtx) ri += 8;
      if (rxe) ri += 1;
      if (dpf) ri += 8;
      if (fbe) ri += 8;
      m_t = (m_t + ti > 511) ? 511 : m_t + ti;
      m_r = (m_r + ri > 255) ? 255 : m_r + ri;
      if (txok && m_t > 0) m_t--;
      if (rxok) m_r = (m_r > 127) ? 127 : ((m_r > 0) ? m_r - 1 : 0);
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    zero();
  endtask

  initial begin
    zero();
    @(negedge clk); @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 idle");
    for (int i = 0; i < 3; i++) begin rxe = 1; step("R3 rx error"); end
    rxok = 1; step("R7 rx ok dec");
    for (int i = 0; i < 3; i++) begin rxok = 1; step("R7 rx ok floor"); end
    for (int i = 0; i < 2; i++) begin txe = 1; step("R2 tx error"); end
    txok = 1; step("R6 tx ok dec");
    dpf = 1; step("R4 dominant after flag");
    fbe = 1; step("R4 flag bit error");
    dpf = 1; fbe = 1; step("R4 both");
    drn = 1; rtx = 1; step("R5 run as tx");
    drn = 1; rtx = 0; step("R5 run as rx");
    txe = 1; stf = 1; step("R8 stuff exempt");
    txe = 1; ack = 1; step("R8 ack while active");
    txe = 1; txok = 1; step("R13 inc then dec");
    for (int i = 0; i < 16; i++) begin txok = 1; step("R6 drain"); end
    for (int i = 0; i < 12; i++) begin dpf = 1; step("R9 toward passive"); end
    txe = 1; ack = 1; step("R8 ack while passive");
    txe = 1; stf = 1; step("R8 stuff while passive");
    rxok = 1; step("R7 reload");
    for (int i = 0; i < 20; i++) begin fbe = 1; dpf = 1; step("R11 rec saturate"); end
    rxe = 1; step("R11 rec stays");
    dpf = 1; rxok = 1; step("R13 reload after inc");
    clr = 1; txe = 1; rxe = 1; step("R1 clear priority");
    for (int i = 0; i < 33; i++) begin txe = 1; step("R9 toward bus off"); end
    txok = 1; rxe = 1; step("R12 ignored in bus off");
    drn = 1; rtx = 1; rxok = 1; step("R12 still off");
    clr = 1; step("R1 clear from bus off");
    for (int i = 0; i < 20; i++) begin drn = 1; rtx = 0; step("R9 rec passive no off"); end
    fbe = 1; step("R10 flag passive");
    clr = 1; step("R1 final clear");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: expected=finished actual=hung");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule